// File: doc/BRIEF.md
# Memory Region Decoder with Access Timing

This block sits between a processor core and its external memory bus. Each access the core presents carries a 21-bit address. The block sorts that address into one of six classes: multiplexed-address DRAM, a slow static window, a fast static window, a slow ROM window, a fast ROM window, or an internal register space. It asserts the matching device strobe and holds the core stalled until the access time for that class has run out. When the access ends it returns the read data and pulses a done strobe.

The slow and fast windows can reach the same devices. They differ only in how many cycles the strobe is held. Bus addresses carry a fixed polarity bias that is XORed onto the core address. For ROM accesses, the two top bus lines come from a two-bit page register, which the core writes through the register space. The boot ROM is one byte wide, so ROM reads return only the low byte of the bus. After reset the core starts fetching from a fixed vector in the slow ROM window. That vector lands on bus address zero.

Top module: `memRegionCtl`

## Requirements
- R1: Addresses 0x000000–0x0FFFFF select DRAM. `dramRasN` stays low for exactly DRAM_CYC cycles. No other select is active during that time.
- R2: During a DRAM access, for the first ROW_HOLD cycles `memAddr[9:0]` carries the row (biased address bits 19:10) and `dramCasN` is high. For the remaining cycles it carries the column (biased bits 9:0) and `dramCasN` is low. `memAddr[19:10]` is zero throughout.
- R3: 0x100000–0x1003FF asserts `sramSlowCsN` for SLOW_WAIT cycles. 0x140000–0x1403FF asserts `sramFastCsN` for FAST_WAIT cycles.
- R4: 0x180000–0x1BFFFF asserts `romSlowCsN` for SLOW_WAIT cycles. 0x1C0000–0x1FFFFF asserts `romFastCsN` for FAST_WAIT cycles.
- R5: For non-ROM devices the bus address is the low 20 address bits XOR 0xAAAAA. `resetVector` reads 0x1AAAAA.
- R6: For ROM accesses, `memAddr[19:18]` is the page register and `memAddr[17:0]` is address bits 17:0 XOR 0x2AAAA. With page 0, the reset vector drives bus address 0.
- R7: 0x160000–0x17FFFF is register space. It keeps the core busy for one cycle and asserts no device select. A write sets the page to data bits 1:0. A read returns the page zero-extended.
- R8: ROM reads return `{13'b0, memRdData[7:0]}`. ROM accesses never pull `memWeN` low.
- R9: Any other address asserts no select. It keeps the core busy for SLOW_WAIT cycles and returns 0x1FFFFF.
- R10: `busy` is high from the cycle after an accepted request for exactly the class's cycle count. `doneStb` is high for the single following cycle, with `busy` low. A request is accepted only while `busy` is low, and requests presented while busy are ignored.
- R11: A write to DRAM or a static window holds `memWeN` low for the whole access, with `memWrData` equal to the write data.
- R12: During and right after reset, `busy` and `doneStb` are low, all strobes are high, `memAddr` is zero, and the page is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core presents an access |
| reqAddr | input | 21 | Core address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWrData | input | 21 | Write data |
| busy | output | 1 | Stall to the core while an access runs |
| doneStb | output | 1 | One-cycle pulse after an access ends |
| rdData | output | 21 | Data from the last read |
| resetVector | output | 21 | Fetch address after reset |
| memAddr | output | 20 | External bus address |
| memWrData | output | 21 | External write data |
| memRdData | input | 21 | External read data |
| memWeN | output | 1 | Active-low write enable |
| dramRasN | output | 1 | DRAM row strobe |
| dramCasN | output | 1 | DRAM column strobe |
| sramSlowCsN | output | 1 | Slow static window select |
| sramFastCsN | output | 1 | Fast static window select |
| romSlowCsN | output | 1 | Slow ROM window select |
| romFastCsN | output | 1 | Fast ROM window select |

## Verification
The bench builds the block with SLOW_WAIT=7, FAST_WAIT=3, DRAM_CYC=6 and ROW_HOLD=2. With three distinct window lengths, a one-cycle register access and an early row/column switch, every select edge, every DRAM phase change and every back-to-back hand-off falls within a few cycles. The fast and slow windows of the same device class remain distinguishable by their length alone. The page-register path is exercised from reset value 0 to page 3, and the effect is observed on the ROM bus lines of the next access.

// File: rtl/memRegionPkg.sv
package memRegionPkg;
  localparam int ADDR_W      = 21;
  localparam int DATA_W      = 21;
  localparam int BUS_W       = 20;
  localparam int ROM_OFS_W   = 18;
  localparam int PAGE_W      = BUS_W - ROM_OFS_W;
  localparam int DRAM_HALF_W = BUS_W / 2;
  localparam int BYTE_W      = 8;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_DRAM,
    RG_SRAM_SLOW,
    RG_SRAM_FAST,
    RG_ROM_SLOW,
    RG_ROM_FAST,
    RG_REG
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // request accepted this cycle
    logic active;    // access in progress
    logic colPhase;  // DRAM column half of the cycle
    logic finish;    // last cycle of the access
  } ctlStrobe_t;
endpackage

// File: rtl/mrcDecode.sv
module mrcDecode
  import memRegionPkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  logic unusedLowBits;
  assign unusedLowBits = ^addr[9:0];

  always_comb begin
    region = RG_NONE;
    if (!addr[20]) begin
      region = RG_DRAM;
    end else begin
      unique case (addr[19:18])
        2'b00: region = (addr[17:10] == '0) ? RG_SRAM_SLOW : RG_NONE;
        2'b01: begin
          if (addr[17])                 region = RG_REG;
          else if (addr[16:10] == '0)   region = RG_SRAM_FAST;
          else                          region = RG_NONE;
        end
        2'b10: region = RG_ROM_SLOW;
        default: region = RG_ROM_FAST;
      endcase
    end
  end
endmodule

// File: rtl/mrcControl.sv
module mrcControl
  import memRegionPkg::*;
#(
  parameter int SLOW_WAIT = 25,
  parameter int FAST_WAIT = 4,
  parameter int DRAM_CYC  = 10,
  parameter int ROW_HOLD  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  region_e    regionIn,
  input  region_e    regionQ,
  output ctlStrobe_t strb,
  output logic       busy,
  output logic       doneStb
);
  localparam int MAX_A    = (SLOW_WAIT > FAST_WAIT) ? SLOW_WAIT : FAST_WAIT;
  localparam int MAX_WAIT = (MAX_A > DRAM_CYC) ? MAX_A : DRAM_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  typedef enum logic {ST_IDLE, ST_ACCESS} state_e;

  state_e           state;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] limit;

  function automatic logic [CNT_W-1:0] limitFor(input region_e r);
    case (r)
      RG_DRAM:                  return CNT_W'(DRAM_CYC);
      RG_SRAM_FAST, RG_ROM_FAST: return CNT_W'(FAST_WAIT);
      RG_REG:                   return CNT_W'(1);
      default:                  return CNT_W'(SLOW_WAIT);
    endcase
  endfunction

  always_comb begin
    strb.load     = reqValid && (state == ST_IDLE);
    strb.active   = (state == ST_ACCESS);
    strb.colPhase = strb.active && (regionQ == RG_DRAM) && (elapsed >= CNT_W'(ROW_HOLD));
    strb.finish   = strb.active && (elapsed == limit - CNT_W'(1));
  end

  assign busy = strb.active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elapsed <= '0;
      limit   <= CNT_W'(1);
      doneStb <= 1'b0;
    end else begin
      doneStb <= strb.finish;
      if (strb.load) begin
        state   <= ST_ACCESS;
        elapsed <= '0;
        limit   <= limitFor(regionIn);
      end else if (strb.finish) begin
        state <= ST_IDLE;
      end else if (strb.active) begin
        elapsed <= elapsed + CNT_W'(1);
      end
    end
  end

  // R10: busy only starts from a presented request
  a_r10_busy_from_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
  // R10: an access keeps running until its last cycle
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> busy);
  // R10: done pulse follows a busy cycle and coincides with idle
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> ($past(busy) && !busy));
endmodule

// File: rtl/mrcDatapath.sv
module mrcDatapath
  import memRegionPkg::*;
#(
  parameter logic [BUS_W-1:0] BUS_BIAS = 20'hAAAAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  region_e           regionIn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWrData,
  output region_e           regionQ,
  output logic [BUS_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWeN,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              sramSlowCsN,
  output logic              sramFastCsN,
  output logic              romSlowCsN,
  output logic              romFastCsN,
  output logic [DATA_W-1:0] rdData
);
  localparam int NCS = 4;
  localparam region_e CS_REGION [NCS] = '{RG_SRAM_SLOW, RG_SRAM_FAST, RG_ROM_SLOW, RG_ROM_FAST};

  logic [BUS_W-1:0]  addrQ;
  logic              wrQ;
  logic [PAGE_W-1:0] romPage;
  logic [BUS_W-1:0]  biased;
  logic [NCS-1:0]    csN;
  logic              unusedAddrTop;

  assign unusedAddrTop = reqAddr[ADDR_W-1];
  assign biased        = addrQ ^ BUS_BIAS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      wrQ       <= 1'b0;
      regionQ   <= RG_NONE;
      memWrData <= '0;
      romPage   <= '0;
      rdData    <= '0;
    end else begin
      if (strb.load) begin
        addrQ     <= reqAddr[BUS_W-1:0];
        wrQ       <= reqWrite;
        regionQ   <= regionIn;
        memWrData <= reqWrData;
      end
      if (strb.finish && wrQ && (regionQ == RG_REG)) begin
        romPage <= memWrData[PAGE_W-1:0];
      end
      if (strb.finish && !wrQ) begin
        case (regionQ)
          RG_DRAM, RG_SRAM_SLOW, RG_SRAM_FAST: rdData <= memRdData;
          RG_ROM_SLOW, RG_ROM_FAST:            rdData <= {{(DATA_W-BYTE_W){1'b0}}, memRdData[BYTE_W-1:0]};
          RG_REG:                              rdData <= {{(DATA_W-PAGE_W){1'b0}}, romPage};
          default:                             rdData <= '1;
        endcase
      end
    end
  end

  // bus address multiplexer
  always_comb begin
    memAddr = '0;
    if (strb.active) begin
      case (regionQ)
        RG_DRAM: memAddr = strb.colPhase
                         ? {{(BUS_W-DRAM_HALF_W){1'b0}}, biased[DRAM_HALF_W-1:0]}
                         : {{(BUS_W-DRAM_HALF_W){1'b0}}, biased[BUS_W-1:DRAM_HALF_W]};
        RG_ROM_SLOW, RG_ROM_FAST: memAddr = {romPage, biased[ROM_OFS_W-1:0]};
        default: memAddr = biased;
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign csN[i] = !(strb.active && (regionQ == CS_REGION[i]));
  end

  assign sramSlowCsN = csN[0];
  assign sramFastCsN = csN[1];
  assign romSlowCsN  = csN[2];
  assign romFastCsN  = csN[3];
  assign dramRasN    = !(strb.active && (regionQ == RG_DRAM));
  assign dramCasN    = !strb.colPhase;
  assign memWeN      = !(strb.active && wrQ &&
                         (regionQ == RG_DRAM || regionQ == RG_SRAM_SLOW || regionQ == RG_SRAM_FAST));

  // R1: at most one device strobe at a time
  a_r1_single_device: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~dramRasN, ~csN}));
  // R2: column strobe only inside a row strobe
  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);
  // R7: page changes only after a register-space write completes
  a_r7_page_by_reg_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(romPage) |-> $past(strb.finish && wrQ && regionQ == RG_REG));
  // R8: no write enable while a ROM is selected
  a_r8_rom_not_written: assert property (@(posedge clk) disable iff (!rstN)
    (!romSlowCsN || !romFastCsN) |-> memWeN);
  // R9: unmapped accesses leave every strobe idle
  a_r9_unmapped_silent: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && regionQ == RG_NONE) |-> (&csN && dramRasN && memWeN));
endmodule

// File: rtl/memRegionCtl.sv
module memRegionCtl
  import memRegionPkg::*;
#(
  parameter int                SLOW_WAIT = 25,
  parameter int                FAST_WAIT = 4,
  parameter int                DRAM_CYC  = 10,
  parameter int                ROW_HOLD  = 4,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 21'h1AAAAA,
  parameter logic [BUS_W-1:0]  BUS_BIAS  = 20'hAAAAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              busy,
  output logic              doneStb,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] resetVector,
  output logic [BUS_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWeN,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              sramSlowCsN,
  output logic              sramFastCsN,
  output logic              romSlowCsN,
  output logic              romFastCsN
);
  region_e    regionIn;
  region_e    regionQ;
  ctlStrobe_t strb;

  assign resetVector = BOOT_ADDR;

  mrcDecode uDecode (
    .addr   (reqAddr),
    .region (regionIn)
  );

  mrcControl #(
    .SLOW_WAIT (SLOW_WAIT),
    .FAST_WAIT (FAST_WAIT),
    .DRAM_CYC  (DRAM_CYC),
    .ROW_HOLD  (ROW_HOLD)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .regionIn (regionIn),
    .regionQ  (regionQ),
    .strb     (strb),
    .busy     (busy),
    .doneStb  (doneStb)
  );

  mrcDatapath #(
    .BUS_BIAS (BUS_BIAS)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .regionIn    (regionIn),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqWrData   (reqWrData),
    .regionQ     (regionQ),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .memRdData   (memRdData),
    .memWeN      (memWeN),
    .dramRasN    (dramRasN),
    .dramCasN    (dramCasN),
    .sramSlowCsN (sramSlowCsN),
    .sramFastCsN (sramFastCsN),
    .romSlowCsN  (romSlowCsN),
    .romFastCsN  (romFastCsN),
    .rdData      (rdData)
  );
endmodule

// File: tb/memRegionCtl_test.sv
`timescale 1ns/1ps
module memRegionCtl_test;
  localparam int SW = 7;
  localparam int FW = 3;
  localparam int DC = 6;
  localparam int RH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [20:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [20:0] reqWrData = '0;
  logic        busy, doneStb, memWeN, dramRasN, dramCasN;
  logic        sramSlowCsN, sramFastCsN, romSlowCsN, romFastCsN;
  logic [20:0] rdData, resetVector, memWrData;
  logic [20:0] memRdData = '0;
  logic [19:0] memAddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  int pageModel = 0;
  int rdModel = 0;

  always #2.5 clk = ~clk;

  memRegionCtl #(.SLOW_WAIT(SW), .FAST_WAIT(FW), .DRAM_CYC(DC), .ROW_HOLD(RH)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWrData(reqWrData), .busy(busy), .doneStb(doneStb), .rdData(rdData),
    .resetVector(resetVector), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memWeN(memWeN), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .sramSlowCsN(sramSlowCsN), .sramFastCsN(sramFastCsN), .romSlowCsN(romSlowCsN),
    .romFastCsN(romFastCsN));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 none, 1 dram, 2 sram slow, 3 sram fast, 4 rom slow, 5 rom fast, 6 reg
  function automatic int classOf(input int a);
    if (a < 'h100000) return 1;
    if (a <= 'h1003FF) return 2;
    if (a >= 'h140000 && a <= 'h1403FF) return 3;
    if (a >= 'h160000 && a < 'h180000) return 6;
    if (a >= 'h180000 && a < 'h1C0000) return 4;
    if (a >= 'h1C0000) return 5;
    return 0;
  endfunction

  function automatic int lenOf(input int c);
    case (c)
      1: return DC;
      3, 5: return FW;
      6: return 1;
      default: return SW;
    endcase
  endfunction

  function automatic string tagOf(input int c);
    case (c)
      1: return "R1";
      2, 3: return "R3";
      4, 5: return "R4";
      6: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic int busAddrOf(input int a, input int c, input int k, input int pg);
    int b;
    b = (a & 'hFFFFF) ^ 'hAAAAA;
    if (c == 1) return (k < RH) ? (b >> 10) : (b & 'h3FF);
    if (c == 4 || c == 5) return (pg << 18) | (b & 'h3FFFF);
    return b;
  endfunction

  // one access, compared against the model on every cycle
  task automatic run(input int a, input bit wr, input int wd, input int md, input bit holdOther);
    int c, n;
    string t;
    c = classOf(a);
    n = lenOf(c);
    t = tagOf(c);
    reqAddr = a[20:0]; reqWrite = wr; reqWrData = wd[20:0]; reqValid = 1'b1;
    memRdData = md[20:0];
    @(posedge clk); @(negedge clk);
    if (holdOther) begin reqAddr = 21'h1C0000; reqWrite = 1'b0; end
    else reqValid = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk({"R10 busy ", t}, busy, 1);
      chk({"R10 done low ", t}, doneStb, 0);
      chk({t, " dram ras"}, dramRasN, (c == 1) ? 0 : 1);
      chk({"R2 cas ", t}, dramCasN, (c == 1 && k >= RH) ? 0 : 1);
      chk({t, " sram slow cs"}, sramSlowCsN, (c == 2) ? 0 : 1);
      chk({t, " sram fast cs"}, sramFastCsN, (c == 3) ? 0 : 1);
      chk({t, " rom slow cs"}, romSlowCsN, (c == 4) ? 0 : 1);
      chk({t, " rom fast cs"}, romFastCsN, (c == 5) ? 0 : 1);
      chk({(c == 1) ? "R2" : (c == 4 || c == 5) ? "R6" : "R5", " bus address"},
          memAddr, busAddrOf(a, c, k, pageModel));
      chk("R11 write enable", memWeN, (wr && c >= 1 && c <= 3) ? 0 : 1);
      if (wr) chk("R11 write data", memWrData, wd & 'h1FFFFF);
      @(posedge clk); @(negedge clk);
    end
    reqValid = 1'b0;
    if (!wr) begin
      case (c)
        1, 2, 3: rdModel = md & 'h1FFFFF;
        4, 5: rdModel = md & 'hFF;
        6: rdModel = pageModel;
        default: rdModel = 'h1FFFFF;
      endcase
    end else if (c == 6) begin
      pageModel = wd & 3;
    end
    chk({"R10 idle after ", t}, busy, 0);
    chk({"R10 done pulse ", t}, doneStb, 1);
    chk({(c == 4 || c == 5) ? "R8" : t, " read data"}, rdData, rdModel);
    chk("R12 bus address idle", memAddr, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset values
    chk("R12 busy", busy, 0);
    chk("R12 done", doneStb, 0);
    chk("R12 ras", dramRasN, 1);
    chk("R12 cas", dramCasN, 1);
    chk("R12 selects", {sramSlowCsN, sramFastCsN, romSlowCsN, romFastCsN, memWeN}, 5'h1F);
    chk("R12 bus address", memAddr, 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R12 busy after release", busy, 0);
    chk("R5 reset vector", resetVector, 'h1AAAAA);
    // R6 boot fetch: slow ROM at bus address 0, byte read (R8)
    run('h1AAAAA, 0, 0, 'h1F5A3C, 0);
    chk("R6 boot lands on bus zero", busAddrOf('h1AAAAA, 4, 0, 0), 0);
    // R1 R2 DRAM read and write
    run('h012345, 0, 0, 'h0ABCDE, 0);
    run('h0FFFFF, 1, 'h155555, 0, 0);
    run('h000000, 0, 0, 'h1FFFFF, 0);
    // R3 static windows, edges of each range
    run('h1003FF, 0, 0, 'h123456, 0);
    run('h100000, 1, 'h0F0F0F, 0, 0);
    run('h140155, 0, 0, 'h054321, 0);
    run('h1403FF, 1, 'h1ABCDE, 0, 0);
    // R4 R8 ROM windows, write never enables
    run('h1C1234, 0, 0, 'h1234A5, 0);
    run('h180010, 1, 'h1FFFFF, 0, 0);
    run('h1BFFFF, 0, 0, 'h000077, 0);
    // R7 page register, then ROM bus lines (R6)
    run('h160000, 0, 0, 'h1FFFFF, 0);
    run('h17FFFF, 1, 'h000007, 0, 0);
    run('h160004, 0, 0, 0, 0);
    run('h1A0000, 0, 0, 'h0000C3, 0);
    run('h1FFFFF, 0, 0, 'h0001EE, 0);
    run('h160000, 1, 'h1FFFF2, 0, 0);
    run('h1C0000, 0, 0, 'h000011, 0);
    // R9 unmapped holes
    run('h100400, 0, 0, 'h012345, 0);
    run('h150000, 1, 'h012345, 0, 0);
    run('h140400, 0, 0, 0, 0);
    // R10 requests while busy are ignored; back-to-back accept
    run('h054321, 0, 0, 'h0C0C0C, 1);
    run('h140001, 0, 0, 'h077777, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule